// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit with Signed Compare Flags

This block is a purely combinational arithmetic unit for two's complement operands of a configurable width. One chain of full-adder cells does all the work. A single mode input picks the operation. In add mode the second operand enters the chain unchanged with a carry-in of zero. In subtract mode every bit of the second operand is inverted and the carry-in is set to one, which supplies the +1 of negation.

The unit drives the wrapped result, the carry leaving the top cell and a signed overflow flag. In subtract mode it also reports four signed comparison results, all derived from the difference: negative, zero (which means the operands are equal), less-than and less-or-equal. The less-than output is corrected by the overflow flag, so it stays right even when the difference itself wraps. Designers instantiate the unit wherever a small adder must also act as a signed comparator. The width parameter defaults to 4 bits.

Top module: `addsub_cmp`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 2^W and `carry_out` is bit W of the unsigned sum.
- R2: With `sub_mode` = 1, `result` equals (`op_a` - `op_b`) modulo 2^W and `carry_out` is 1 exactly when `op_a` >= `op_b` read as unsigned numbers.
- R3: In both modes, `overflow` is 1 exactly when the carry entering the top cell differs from the carry leaving it. This is the case where the signed result lies outside [-2^(W-1), 2^(W-1)-1].
- R4: At W = 4, 0101 + 0011 gives `result` 1000 with `overflow` 1, and 1001 - 0010 gives `result` 0111 with `overflow` 1.
- R5: With `sub_mode` = 1, `neg_flag` equals the top bit of `result`.
- R6: With `sub_mode` = 1, `zero_flag` is 1 exactly when every bit of `result` is 0, that is when `op_a` equals `op_b`.
- R7: With `sub_mode` = 1, `lt_flag` is 1 exactly when `op_a` < `op_b` as signed values. It is computed as the top result bit XOR `overflow`, so it stays correct when the difference overflows.
- R8: With `sub_mode` = 1, `le_flag` equals `zero_flag` OR `lt_flag`, that is signed `op_a` <= `op_b`.
- R9: With `sub_mode` = 0, `neg_flag`, `zero_flag`, `lt_flag` and `le_flag` are all 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand, two's complement |
| op_b | input | W | Second operand, two's complement |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract (op_a - op_b) |
| result | output | W | Sum or difference, wrapped to W bits |
| carry_out | output | 1 | Carry leaving the top cell |
| overflow | output | 1 | Signed overflow of the current operation |
| neg_flag | output | 1 | Difference is negative (subtract mode only) |
| zero_flag | output | 1 | Operands are equal (subtract mode only) |
| lt_flag | output | 1 | Signed op_a < op_b (subtract mode only) |
| le_flag | output | 1 | Signed op_a <= op_b (subtract mode only) |

## Verification
Overflow detection and the less-than comparison can both be active on the same input vector. This happens when a subtraction of operands with opposite signs wraps, for example the most negative value minus a positive one. In that case the raw sign bit of the difference gives the wrong answer and only the overflow-corrected flag is right. The 4-bit instance is driven through every operand pair in both modes, which reaches every such wrapping case. Random vectors on a 16-bit instance add more. Each flag is judged against integer arithmetic and signed integer comparison done in the bench.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic lt;
        logic le;
    } cmp_flags_t;

    function automatic logic bit_sum(input logic x, input logic y, input logic cin);
        return x ^ y ^ cin;
    endfunction

    function automatic logic bit_carry(input logic x, input logic y, input logic cin);
        return (x & y) | (cin & (x | y));
    endfunction

endpackage

// File: rtl/addsub_fa.sv
module addsub_fa
    import addsub_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    assign s    = bit_sum(x, y, cin);
    assign cout = bit_carry(x, y, cin);
endmodule

// File: rtl/addsub_bmux.sv
module addsub_bmux #(
    parameter int W = 4
) (
    input  logic [W-1:0] b_in,
    input  logic         invert,
    output logic [W-1:0] b_out
);
    // Per-bit 2:1 selection between the operand bit and its complement
    for (genvar i = 0; i < W; i++) begin : g_sel
        assign b_out[i] = invert ? ~b_in[i] : b_in[i];
    end
endmodule

// File: rtl/addsub_chain.sv
module addsub_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         c_into_top,
    output logic         c_out
);
    localparam int TOP = W - 1;

    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_cell
        addsub_fa u_fa (
            .x    (x[i]),
            .y    (y[i]),
            .cin  (c[i]),
            .s    (s[i]),
            .cout (c[i+1])
        );
    end

    assign c_into_top = c[TOP];
    assign c_out      = c[W];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] diff,
    input  logic         c_into_top,
    input  logic         c_out,
    input  op_t          op,
    output logic         ovf,
    output cmp_flags_t   flags
);
    localparam int TOP = W - 1;

    logic raw_neg;
    logic raw_zero;
    logic raw_lt;
    logic valid;

    assign ovf      = c_into_top ^ c_out;
    assign raw_neg  = diff[TOP];
    assign raw_zero = (diff == '0);
    assign raw_lt   = raw_neg ^ ovf;
    assign valid    = (op == OP_SUB);

    always_comb begin
        flags      = '0;
        if (valid) begin
            flags.neg  = raw_neg;
            flags.zero = raw_zero;
            flags.lt   = raw_lt;
            flags.le   = raw_zero | raw_lt;
        end
    end
endmodule

// File: rtl/addsub_cmp.sv
module addsub_cmp
    import addsub_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub_mode,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow,
    output logic         neg_flag,
    output logic         zero_flag,
    output logic         lt_flag,
    output logic         le_flag
);
    op_t        op;
    logic       chain_cin;
    logic [W-1:0] b_eff;
    logic       c_top;
    cmp_flags_t flags;

    assign op        = op_t'(sub_mode);
    assign chain_cin = (op == OP_SUB);

    addsub_bmux #(.W(W)) u_bmux (
        .b_in   (op_b),
        .invert (chain_cin),
        .b_out  (b_eff)
    );

    addsub_chain #(.W(W)) u_chain (
        .x          (op_a),
        .y          (b_eff),
        .cin        (chain_cin),
        .s          (result),
        .c_into_top (c_top),
        .c_out      (carry_out)
    );

    addsub_flags #(.W(W)) u_flags (
        .diff       (result),
        .c_into_top (c_top),
        .c_out      (carry_out),
        .op         (op),
        .ovf        (overflow),
        .flags      (flags)
    );

    assign neg_flag  = flags.neg;
    assign zero_flag = flags.zero;
    assign lt_flag   = flags.lt;
    assign le_flag   = flags.le;
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         sub_mode,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         overflow,
    input logic         neg_flag,
    input logic         zero_flag,
    input logic         lt_flag,
    input logic         le_flag
);
    localparam int TOP = W - 1;

    always_comb begin
        // R3: a wrapped result always has a sign opposite to op_a
        p_ovf_sign_r3: assert (!overflow || (result[TOP] != op_a[TOP]))
            else $error("overflow with result sign matching op_a");
        // R9: add mode keeps every compare output low
        p_add_quiet_r9: assert (sub_mode || !(neg_flag | zero_flag | lt_flag | le_flag))
            else $error("compare flag active in add mode");
        // R6: equality flag only for identical operands
        p_zero_equal_r6: assert (!zero_flag || (op_a == op_b))
            else $error("zero flag with unequal operands");
        // R7: strict less-than excludes equality
        p_lt_excl_r7: assert (!(lt_flag && zero_flag))
            else $error("lt and zero both set");
        // R2: equal operands subtract with carry out set
        p_sub_carry_r2: assert (!(sub_mode && (op_a == op_b)) || carry_out)
            else $error("no carry for equal-operand subtraction");
        // R8: less-or-equal covers less-than
        p_le_cover_r8: assert (!lt_flag || le_flag)
            else $error("lt without le");
    end
endmodule

bind addsub_cmp addsub_cmp_chk #(.W(W)) u_addsub_cmp_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .sub_mode  (sub_mode),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .neg_flag  (neg_flag),
    .zero_flag (zero_flag),
    .lt_flag   (lt_flag),
    .le_flag   (le_flag)
);

// File: tb/addsub_cmp_bench.sv
module addsub_cmp_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [3:0]  a4, b4, r4;
    logic        s4, co4, ov4, n4, z4, lt4, le4;
    logic [15:0] a16, b16, r16;
    logic        s16, co16, ov16, n16, z16, lt16, le16;

    addsub_cmp #(.W(4)) u_addsub_cmp (
        .op_a(a4), .op_b(b4), .sub_mode(s4), .result(r4), .carry_out(co4),
        .overflow(ov4), .neg_flag(n4), .zero_flag(z4), .lt_flag(lt4), .le_flag(le4)
    );

    addsub_cmp #(.W(16)) u_addsub_cmp_w16 (
        .op_a(a16), .op_b(b16), .sub_mode(s16), .result(r16), .carry_out(co16),
        .overflow(ov16), .neg_flag(n16), .zero_flag(z16), .lt_flag(lt16), .le_flag(le16)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic and comparison
    task automatic judge(input int w, input longint a, input longint b, input bit sub,
                         input longint res, input bit co, input bit ov,
                         input bit n, input bit z, input bit lt, input bit le);
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        longint sa   = (a >= half) ? a - (mask + 1) : a;
        longint sb   = (b >= half) ? b - (mask + 1) : b;
        longint sres = sub ? sa - sb : sa + sb;
        longint eres = (sub ? a - b : a + b) & mask;
        bit     eco  = sub ? (a >= b) : (((a + b) >> w) & 1) == 1;
        bit     eov  = (sres < -half) || (sres > half - 1);
        if (sub) begin
            chk("R2 result", res, eres);
            chk("R2 carry_out", co, eco);
            chk("R5 neg_flag", n, eres >= half);
            chk("R6 zero_flag", z, a == b);
            chk("R7 lt_flag", lt, sa < sb);
            chk("R8 le_flag", le, sa <= sb);
        end else begin
            chk("R1 result", res, eres);
            chk("R1 carry_out", co, eco);
            chk("R9 add-mode flags", {n, z, lt, le}, 0);
        end
        chk("R3 overflow", ov, eov);
    endtask

    task automatic run4(input int a, input int b, input bit sub);
        @(posedge clk);
        a4 = a[3:0]; b4 = b[3:0]; s4 = sub;
        @(negedge clk);
        judge(4, a, b, sub, r4, co4, ov4, n4, z4, lt4, le4);
    endtask

    task automatic run16(input int a, input int b, input bit sub);
        @(posedge clk);
        a16 = a[15:0]; b16 = b[15:0]; s16 = sub;
        @(negedge clk);
        judge(16, a, b, sub, r16, co16, ov16, n16, z16, lt16, le16);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        a4 = '0; b4 = '0; s4 = 1'b0;
        a16 = '0; b16 = '0; s16 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: initial idle state, 0 + 0
        chk("R1 idle result", r4, 0);
        chk("R9 idle flags", {co4, ov4, n4, z4, lt4, le4}, 0);

        // R4: directed overflow cases
        run4(5, 3, 1'b0);
        chk("R4 5+3 result", r4, 4'b1000);
        chk("R4 5+3 overflow", ov4, 1);
        run4(9, 2, 1'b1);
        chk("R4 -7-2 result", r4, 4'b0111);
        chk("R4 -7-2 overflow", ov4, 1);
        // R7: overflowing difference -8 - 1, lt must still be 1
        run4(8, 1, 1'b1);
        chk("R7 -8<1 under overflow", lt4, 1);
        // R7: 7 - (-8) overflows, lt must be 0
        run4(7, 8, 1'b1);
        chk("R7 7<-8 under overflow", lt4, 0);

        // Exhaustive 4-bit sweep, both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run4(a, b, m[0]);

        // 16-bit extremes and random vectors
        run16(16'h8000, 16'h0001, 1'b1);
        run16(16'h7FFF, 16'h7FFF, 1'b0);
        run16(16'h8000, 16'h8000, 1'b1);
        for (int k = 0; k < 3000; k++) begin
            int ra = int'($urandom_range(0, 65535));
            int rb = (k % 7 == 0) ? ra : int'($urandom_range(0, 65535));
            run16(ra, rb, k[0]);
        end
        summary();
    end
endmodule